// File: doc/BRIEF.md
# Signature-based transactional conflict detector

This block watches the memory traffic of up to eight hardware threads that run critical sections optimistically instead of taking a lock. Each thread that has opened a transaction gets two bit-vector signatures. One summarises the addresses the thread has loaded, the other the addresses it has stored. Every address is reduced by a hash to a single bit position, and that bit is set in the matching signature.

Each cycle, one access can arrive on the access port. If the access comes from a thread with an open transaction, it is compared against the signatures of every other open transaction. A load collides with their write signatures. A store collides with both their read and their write signatures. A collision raises `conflict` in the same cycle and names the issuing thread as the one to abort.

The hash can alias, so false conflicts are possible. A true conflict is never missed. Restoring memory after an abort and retrying the section are left to the surrounding logic, which drives the per-thread begin, commit and abort strobes.

Top module: `txn_conflict_sig`

## Requirements
- R1: After reset no transaction is open, `conflict` is low and `conflict_tid` is zero.
- R2: The hash index of an address is the XOR-fold of its word address bits (addr[ADDR_W-1:2]): word bit k is folded into index bit k mod log2(SIG_W). Addresses that differ only in bits [1:0] map to the same index.
- R3: A load that meets only loads of other open transactions at the same index does not raise `conflict`.
- R4: A load whose index is set in the write signature of another open transaction raises `conflict` in the cycle of the load.
- R5: A store whose index is set in the read signature or the write signature of another open transaction raises `conflict` in the cycle of the store.
- R6: A thread's own earlier accesses never cause it a conflict, and the check uses the signatures as they stood before the current access.
- R7: While `conflict` is high, `conflict_tid` equals the issuing thread `acc_tid`. Otherwise `conflict_tid` is zero.
- R8: An access from a thread with no open transaction is not checked and not recorded. It never raises `conflict` and never causes a later conflict.
- R9: A commit or abort strobe closes the thread's transaction and empties both its signatures at the same clock edge. A begin strobe opens the transaction with empty signatures. Commit and abort take priority over begin.
- R10: Two different addresses that share a hash index are reported as a conflict when the access types collide (an allowed false conflict).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_tid | input | TID_W | Issuing thread |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_write | input | 1 | 1 = store, 0 = load |
| txn_begin | input | NUM_THREADS | Per-thread transaction open strobe |
| txn_commit | input | NUM_THREADS | Per-thread commit strobe |
| txn_abort | input | NUM_THREADS | Per-thread abort strobe |
| conflict | output | 1 | The current access collides with another open transaction |
| conflict_tid | output | TID_W | Thread to abort (the issuer), zero when there is no conflict |

## Verification
On every cycle, the assertions check the following:
- the link between `conflict` and `conflict_tid`;
- that a conflict can only come from a valid access of an open transaction;
- that a commit or abort closes its transaction at the next edge, and that a begin alone opens it.

Only the bench scenarios can show the detection itself:
- the load/store collision matrix, swept over every ordered thread pair;
- the hash aliasing swept over 64 neighbouring words;
- that closed or re-opened transactions forget their history.

// File: rtl/txn_conflict_sig.sv
module txn_conflict_sig #(
  parameter int NUM_THREADS = 8,
  parameter int ADDR_W      = 32,
  parameter int SIG_W       = 64,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int IDX_W      = $clog2(SIG_W),
  localparam int WA_W       = ADDR_W - 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_valid,
  input  logic [TID_W-1:0]       acc_tid,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic                   acc_write,
  input  logic [NUM_THREADS-1:0] txn_begin,
  input  logic [NUM_THREADS-1:0] txn_commit,
  input  logic [NUM_THREADS-1:0] txn_abort,
  output logic                   conflict,
  output logic [TID_W-1:0]       conflict_tid
);

  function automatic logic [IDX_W-1:0] fold_hash(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < WA_W; i++) h[i % IDX_W] = h[i % IDX_W] ^ a[i+2];
    return h;
  endfunction

  logic [NUM_THREADS-1:0] active_q;
  logic [SIG_W-1:0]       rsig_q [NUM_THREADS];
  logic [SIG_W-1:0]       wsig_q [NUM_THREADS];

  logic [IDX_W-1:0] idx;
  logic [SIG_W-1:0] bit_sel;
  logic             rec;
  logic             hit;

  assign idx     = fold_hash(acc_addr);
  assign bit_sel = {{(SIG_W-1){1'b0}}, 1'b1} << idx;
  assign rec     = acc_valid && active_q[acc_tid];

  always_comb begin
    hit = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (TID_W'(t) != acc_tid && active_q[t]) begin
        if (wsig_q[t][idx])              hit = 1'b1;
        if (acc_write && rsig_q[t][idx]) hit = 1'b1;
      end
    end
  end

  assign conflict     = rec && hit;
  assign conflict_tid = conflict ? acc_tid : '0;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    logic mine;
    assign mine = rec && (acc_tid == TID_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active_q[g] <= 1'b0;
        rsig_q[g]   <= '0;
        wsig_q[g]   <= '0;
      end else if (txn_commit[g] || txn_abort[g]) begin
        active_q[g] <= 1'b0;
        rsig_q[g]   <= '0;
        wsig_q[g]   <= '0;
      end else if (txn_begin[g]) begin
        active_q[g] <= 1'b1;
        rsig_q[g]   <= '0;
        wsig_q[g]   <= '0;
      end else if (mine) begin
        if (acc_write) wsig_q[g] <= wsig_q[g] | bit_sel;
        else           rsig_q[g] <= rsig_q[g] | bit_sel;
      end
    end
  end

endmodule

// File: rtl/txn_conflict_sig_chk.sv
module txn_conflict_sig_chk #(
  parameter int NUM_THREADS = 8,
  parameter int TID_W       = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_valid,
  input logic [TID_W-1:0]       acc_tid,
  input logic [NUM_THREADS-1:0] txn_begin,
  input logic [NUM_THREADS-1:0] txn_commit,
  input logic [NUM_THREADS-1:0] txn_abort,
  input logic                   conflict,
  input logic [TID_W-1:0]       conflict_tid,
  input logic [NUM_THREADS-1:0] act
);

  a_r7_tid_issuer: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> conflict_tid == acc_tid);

  a_r7_tid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict |-> conflict_tid == '0);

  a_r8_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> acc_valid);

  a_r8_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !act[acc_tid]) |-> !conflict);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    a_r9_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_commit[t] || txn_abort[t]) |=> !act[t]);

    a_r9_begin_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_begin[t] && !txn_commit[t] && !txn_abort[t]) |=> act[t]);
  end

endmodule

bind txn_conflict_sig txn_conflict_sig_chk #(
  .NUM_THREADS(NUM_THREADS),
  .TID_W(TID_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .acc_valid(acc_valid),
  .acc_tid(acc_tid),
  .txn_begin(txn_begin),
  .txn_commit(txn_commit),
  .txn_abort(txn_abort),
  .conflict(conflict),
  .conflict_tid(conflict_tid),
  .act(active_q)
);

// File: tb/txn_conflict_sig_tb.sv
`timescale 1ns/1ps
module txn_conflict_sig_tb;
  localparam int NT = 8, AW = 32, SW = 64, TW = 3, IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [TW-1:0] acc_tid = '0;
  logic [AW-1:0] acc_addr = '0;
  logic acc_write = 1'b0;
  logic [NT-1:0] bgn = '0, cmt = '0, abt = '0;
  logic conflict;
  logic [TW-1:0] conflict_tid;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  txn_conflict_sig #(.NUM_THREADS(NT), .ADDR_W(AW), .SIG_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_tid(acc_tid),
    .acc_addr(acc_addr), .acc_write(acc_write), .txn_begin(bgn),
    .txn_commit(cmt), .txn_abort(abt), .conflict(conflict),
    .conflict_tid(conflict_tid));

  function automatic logic [IW-1:0] hsh(input logic [AW-1:0] a);
    logic [IW-1:0] h = '0;
    for (int i = 2; i < AW; i++) h[(i-2) % IW] ^= a[i];
    return h;
  endfunction

  task automatic chk(input string req, input logic ec, input logic [TW-1:0] et);
    checks++;
    if (conflict !== ec || conflict_tid !== et) begin
      errors++;
      $display("FAIL %s: conflict=%0b tid=%0d expected conflict=%0b tid=%0d",
               req, conflict, conflict_tid, ec, et);
    end
  endtask

  task automatic acc(input int t, input logic [AW-1:0] a, input logic w,
                     input logic ec, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_tid = TW'(t); acc_addr = a; acc_write = w;
    #1 chk(req, ec, ec ? TW'(t) : '0);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic strobe(input logic [NT-1:0] b, input logic [NT-1:0] c, input logic [NT-1:0] x);
    @(negedge clk);
    bgn = b; cmt = c; abt = x;
    @(negedge clk);
    bgn = '0; cmt = '0; abt = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] A;
    A = 32'h0000_1000;
    repeat (3) @(negedge clk);
    #1 chk("R1 reset outputs", 1'b0, '0);
    rst_n = 1'b1;
    // R1: nothing open after reset, so accesses are ignored
    acc(1, A, 1'b1, 1'b0, "R1 no open txn after reset");
    acc(2, A, 1'b1, 1'b0, "R1 no open txn after reset");

    // R3 R4 R5 R7: all ordered thread pairs, all access-type pairs
    for (int i = 0; i < NT; i++)
      for (int j = 0; j < NT; j++)
        if (i != j)
          for (int m = 0; m < 4; m++) begin
            logic w1, w2;
            w1 = m[0]; w2 = m[1];
            strobe((NT'(1) << i) | (NT'(1) << j), '0, '0);
            acc(j, A, w1, 1'b0, "R6 first access clean");
            acc(i, A, w2, w1 | w2,
                (w1 | w2) ? (w2 ? "R5 store vs other sig" : "R4 load vs other write")
                          : "R3 read-read");
            strobe('0, '0, (NT'(1) << i) | (NT'(1) << j));
          end

    // R2 R10: sweep 64 neighbouring words against a write at A
    strobe(8'h03, '0, '0);
    acc(0, A, 1'b1, 1'b0, "R2 setup");
    for (int k = 1; k < 64; k++) begin
      logic [AW-1:0] X;
      X = A + 32'(4*k);
      acc(1, X, 1'b0, hsh(X) == hsh(A), hsh(X) == hsh(A) ? "R10 alias" : "R2 distinct index");
    end
    acc(1, A ^ 32'h3, 1'b0, 1'b1, "R2 byte offset same index");
    acc(1, A ^ 32'h104, 1'b1, 1'b1, "R10 folded alias");
    strobe('0, 8'h03, '0);

    // R6: own history never conflicts
    strobe(8'h10, '0, '0);
    acc(4, A, 1'b1, 1'b0, "R6 own write");
    acc(4, A, 1'b0, 1'b0, "R6 own read after write");
    acc(4, A, 1'b1, 1'b0, "R6 own rewrite");
    strobe('0, '0, 8'h10);

    // R8: inactive accesses are neither recorded nor checked
    strobe(8'h20, '0, '0);
    acc(5, A, 1'b1, 1'b0, "R8 setup");
    acc(6, A, 1'b1, 1'b0, "R8 inactive unchecked");
    strobe(8'h40, '0, '0);
    acc(6, A, 1'b0, 1'b1, "R4 after open");
    strobe('0, '0, 8'h20);
    acc(6, A, 1'b1, 1'b0, "R8 setup2");
    strobe('0, '0, 8'h40);
    acc(7, A, 1'b1, 1'b0, "R8 inactive store");
    strobe(8'h81, '0, '0);
    acc(0, A, 1'b0, 1'b0, "R8 inactive store left no trace");
    strobe('0, 8'h81, '0);

    // R9: commit empties, re-begin empties, commit beats begin
    strobe(8'h06, '0, '0);
    acc(1, A, 1'b1, 1'b0, "R9 setup");
    strobe('0, 8'h02, '0);
    acc(2, A, 1'b1, 1'b0, "R9 commit cleared");
    acc(1, A, 1'b1, 1'b0, "R9 closed after commit");
    strobe(8'h02, '0, '0);
    acc(1, A, 1'b0, 1'b1, "R4 reopened sees write");
    acc(2, A, 1'b0, 1'b0, "R9 setup3");
    strobe(8'h04, '0, '0);
    acc(1, A, 1'b1, 1'b0, "R9 begin cleared sig");
    strobe(8'h02, 8'h02, '0);
    acc(1, A, 1'b1, 1'b0, "R9 commit wins over begin");
    strobe('0, '0, 8'h06);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule